// File: doc/BRIEF.md
# Serial EEPROM Select-Code Decoder

This block is the slave-side front end of a two-wire serial presence-detect EEPROM. It watches already-synchronised samples of the clock and data lines. After a Start condition it shifts in the first byte of the transfer and decides what that byte addresses. The byte can address the memory array or the write-protection command space, or it can address nothing on this device. When the byte is accepted, the block pulls the data line low for the whole ninth clock. It then reports itself selected and holds the requested direction.

Memory-array traffic is accepted only when the three chip-enable bits in the byte equal the strap inputs, so several devices can share one bus. Protection traffic uses its own type code. Its set and clear commands, and their reads, use fixed chip-enable codes and require a high-voltage level on the A0 strap. The permanent command matches the straps instead. The block keeps the protection flags itself. Once the permanent flag is set, no write command can change the flags again. While the supply is below its power-good level the block ignores the bus. The data phase that follows the select byte and the write-cycle timing belong to other blocks.

Top module: `eesel_top`

## Requirements
- R1: No byte is decoded and no acknowledge is given unless a Start condition (data falling while the clock is high) came first. Bits clocked after a Stop without a new Start are ignored.
- R2: The select byte is taken on rising clock edges, most significant bit first. Bits [7:4] are the type code, bits [3:1] are chip-enable A2..A0, and bit [0] is the direction (1 = read, 0 = write).
- R3: Type 4'b1010 with chip-enable equal to `ce_strap` is acknowledged. After the ninth clock, `selected` is 1 and `rd_wr` equals bit 0 of the byte.
- R4: An unknown type code, or a chip-enable mismatch, gets no acknowledge. The block then stays deselected and ignores all bits until the next Start.
- R5: Type 4'b0110 with chip-enable 3'b001, direction 0 and `a0_hv` = 1 is acknowledged and sets `prot_active`.
- R6: Type 4'b0110 with chip-enable 3'b011, direction 0 and `a0_hv` = 1 is acknowledged and clears `prot_active`.
- R7: A fixed-code protection command (chip-enable 001 or 011) with `a0_hv` = 0 gets no acknowledge and leaves the flags unchanged, provided the straps differ from that code.
- R8: Type 4'b0110 with chip-enable equal to `ce_strap`, direction 0 and `a0_hv` = 0 is acknowledged. It sets both `prot_perm` and `prot_active`.
- R9: While `prot_perm` is 1, every protection write (set, clear or permanent) gets no acknowledge and leaves the flags unchanged. `prot_perm` never returns to 0 except by reset.
- R10: Protection reads (direction 1) with a valid code are acknowledged and change no flag, even while `prot_perm` is 1.
- R11: While `pwr_good` is 0 the block gives no acknowledge and does not become selected.
- R12: A Stop in the middle of the select byte aborts decoding without an acknowledge. A repeated Start in the middle of the byte discards the partial bits and begins a new byte.
- R13: The acknowledge pull-down starts after the eighth falling clock edge. It ends on the ninth falling edge, and it changes only while the clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl | input | 1 | Synchronised bus clock sample |
| sda | input | 1 | Synchronised bus data sample (wired line) |
| ce_strap | input | 3 | Chip-enable strap levels A2..A0 |
| a0_hv | input | 1 | High-voltage detected on A0 strap |
| pwr_good | input | 1 | Supply above power-on-reset threshold |
| sda_pull | output | 1 | Drive bus data low (acknowledge) |
| selected | output | 1 | Select byte accepted, transfer in progress |
| rd_wr | output | 1 | Direction of the accepted select byte |
| prot_active | output | 1 | Write protection in force |
| prot_perm | output | 1 | Permanent protection set |

## Verification
On every cycle the assertions check these rules: the permanent flag never falls and always implies active protection, no pull-down is driven without power, a Stop clears both pull-down and selection on the next cycle, and the pull-down only switches while the clock is low. Only the directed scenarios can show whether a given byte is acknowledged or refused: the decoding of the type and chip-enable codes, the high-voltage rule, the refusals after permanent protection, standby after a mismatch, and recovery from an aborted byte.

// File: rtl/eesel_pkg.sv
// Package: shared codes and types of the select-code decoder.
// Assumes an eight-bit select byte, type code in the upper nibble.
package eesel_pkg;
    localparam int SEL_W = 8;
    localparam logic [3:0] ARRAY_TYPE = 4'b1010;
    localparam logic [3:0] PROT_TYPE  = 4'b0110;
    localparam logic [2:0] SET_CE     = 3'b001;
    localparam logic [2:0] CLR_CE     = 3'b011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ACK,
        ST_HOLD,
        ST_STANDBY
    } bus_state_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_SET,
        OP_CLR,
        OP_PERM
    } prot_op_t;
endpackage

// File: rtl/eesel_bus_cond.sv
// Module: bus condition detector.
// Detects Start, Stop and both clock edges from one cycle of history.
// Assumes scl/sda are already synchronised to clk.
module eesel_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q;
    logic sda_q;

    // Keep the previous line samples; the idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Classify the current transition of the two lines.
    always_comb begin
        start_det = scl_q & scl & sda_q & ~sda;
        stop_det  = scl_q & scl & ~sda_q & sda;
        scl_rise  = ~scl_q & scl;
        scl_fall  = scl_q & ~scl;
    end
endmodule

// File: rtl/eesel_shift.sv
// Module: select-byte shift register.
// Shifts data in MSB first on each rising clock edge and flags a full byte.
// Assumes the caller pulses clear on every Start.
module eesel_shift #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              enable,
    input  logic              scl_rise,
    input  logic              sda,
    output logic [BYTE_W-1:0] byte_o,
    output logic              full
);
    logic [CNT_W-1:0] cnt;

    // Collect bits and count them; stop counting once a byte is in.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            byte_o <= '0;
            cnt    <= '0;
        end else if (enable && scl_rise && !full) begin
            byte_o <= {byte_o[BYTE_W-2:0], sda};
            cnt    <= cnt + 1'b1;
        end
    end

    // The byte is complete when all bits have been counted.
    always_comb full = (cnt == CNT_W'(BYTE_W));

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(BYTE_W));
endmodule

// File: rtl/eesel_match.sv
// Module: select-code matcher.
// Decides from a complete byte whether to acknowledge and which protection
// operation it requests. Assumes the byte is stable while it is evaluated.
module eesel_match
    import eesel_pkg::*;
(
    input  logic [SEL_W-1:0] sel_byte,
    input  logic [2:0]       ce_strap,
    input  logic             a0_hv,
    input  logic             perm_flag,
    output logic             accept,
    output prot_op_t         op
);
    logic [3:0] type_code;
    logic [2:0] ce_code;
    logic       rw;
    logic       array_hit;
    logic       set_hit;
    logic       clr_hit;
    logic       perm_hit;
    logic       prot_hit;

    // Split the byte into its fields.
    always_comb begin
        type_code = sel_byte[7:4];
        ce_code   = sel_byte[3:1];
        rw        = sel_byte[0];
    end

    // Match the fields against the type codes, the straps and the A0 level.
    always_comb begin
        array_hit = (type_code == ARRAY_TYPE) && (ce_code == ce_strap);
        set_hit   = (type_code == PROT_TYPE) && a0_hv && (ce_code == SET_CE);
        clr_hit   = (type_code == PROT_TYPE) && a0_hv && (ce_code == CLR_CE);
        perm_hit  = (type_code == PROT_TYPE) && !a0_hv && (ce_code == ce_strap);
        prot_hit  = set_hit || clr_hit || perm_hit;
    end

    // Reads of protection state always pass; writes are refused once permanent.
    always_comb begin
        accept = array_hit || (prot_hit && (rw || !perm_flag));
        op     = OP_NONE;
        if (prot_hit && !rw && !perm_flag) begin
            if (set_hit)      op = OP_SET;
            else if (clr_hit) op = OP_CLR;
            else              op = OP_PERM;
        end
    end
endmodule

// File: rtl/eesel_prot.sv
// Module: protection flag store.
// Applies one operation per pulse. Assumes the matcher has already
// refused writes while the permanent flag is set.
module eesel_prot
    import eesel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     apply,
    input  prot_op_t op,
    output logic     prot_active,
    output logic     prot_perm
);
    // Update the flags when an accepted command is applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_active <= 1'b0;
            prot_perm   <= 1'b0;
        end else if (apply && !prot_perm) begin
            case (op)
                OP_SET:  prot_active <= 1'b1;
                OP_CLR:  prot_active <= 1'b0;
                OP_PERM: begin
                    prot_active <= 1'b1;
                    prot_perm   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    p_perm_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prot_perm |=> prot_perm);
    p_perm_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prot_perm |-> prot_active);
endmodule

// File: rtl/eesel_top.sv
// Module: serial EEPROM select-code decoder (top).
// Sequences Start, select byte, ninth-clock acknowledge and selection.
// Assumes synchronised line samples and an open-drain data line outside.
module eesel_top
    import eesel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl,
    input  logic       sda,
    input  logic [2:0] ce_strap,
    input  logic       a0_hv,
    input  logic       pwr_good,
    output logic       sda_pull,
    output logic       selected,
    output logic       rd_wr,
    output logic       prot_active,
    output logic       prot_perm
);
    logic             start_det;
    logic             stop_det;
    logic             scl_rise;
    logic             scl_fall;
    logic [SEL_W-1:0] sel_byte;
    logic             byte_full;
    logic             accept;
    prot_op_t         op;
    logic             decide;
    bus_state_t       state;
    logic             ack_rise_seen;

    eesel_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (scl),
        .sda       (sda),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    eesel_shift #(.BYTE_W(SEL_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_det),
        .enable   (state == ST_SHIFT),
        .scl_rise (scl_rise),
        .sda      (sda),
        .byte_o   (sel_byte),
        .full     (byte_full)
    );

    eesel_match u_match (
        .sel_byte  (sel_byte),
        .ce_strap  (ce_strap),
        .a0_hv     (a0_hv),
        .perm_flag (prot_perm),
        .accept    (accept),
        .op        (op)
    );

    // The byte is judged on the falling edge that closes its eighth bit.
    always_comb decide = (state == ST_SHIFT) && byte_full && scl_fall;

    eesel_prot u_prot (
        .clk         (clk),
        .rst_n       (rst_n),
        .apply       (decide && accept && pwr_good),
        .op          (op),
        .prot_active (prot_active),
        .prot_perm   (prot_perm)
    );

    // Transfer sequencing: Start, byte, acknowledge, then hold or standby.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            state         <= ST_IDLE;
            ack_rise_seen <= 1'b0;
            rd_wr         <= 1'b0;
        end else if (start_det) begin
            state         <= ST_SHIFT;
            ack_rise_seen <= 1'b0;
        end else if (stop_det) begin
            state         <= ST_IDLE;
        end else begin
            case (state)
                ST_SHIFT: if (decide) begin
                    state <= accept ? ST_ACK : ST_STANDBY;
                    if (accept) rd_wr <= sel_byte[0];
                end
                ST_ACK: begin
                    if (scl_rise) ack_rise_seen <= 1'b1;
                    if (scl_fall && ack_rise_seen) state <= ST_HOLD;
                end
                default: ;
            endcase
        end
    end

    // Decode the outputs from the sequence state.
    always_comb begin
        sda_pull = (state == ST_ACK);
        selected = (state == ST_ACK) || (state == ST_HOLD);
    end

    p_no_pull_unpowered_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !sda_pull && !selected);
    p_stop_releases_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull && !selected);
    p_pull_edge_low_r13: assert property (@(posedge clk) disable iff (!rst_n || !pwr_good)
        ($rose(sda_pull) || $fell(sda_pull)) |-> !scl);
    p_no_ack_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start_det) |=> !sda_pull);
endmodule

// File: tb/eesel_top_bench.sv
// Directed bench for the select-code decoder; one task per scenario.
module eesel_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PH = 4;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic a0_hv = 1'b0;
    logic pwr_good = 1'b1;
    logic sda_line;
    logic sda_pull, selected, rd_wr, prot_active, prot_perm;
    int   n_checks = 0;
    int   n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    eesel_top u_eesel_top (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_line),
        .ce_strap(STRAP), .a0_hv(a0_hv), .pwr_good(pwr_good),
        .sda_pull(sda_pull), .selected(selected), .rd_wr(rd_wr),
        .prot_active(prot_active), .prot_perm(prot_perm)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wait_ph(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_ph(PH);
        scl = 1'b1;   wait_ph(PH);
        sda_m = 1'b0; wait_ph(PH);
        scl = 1'b0;   wait_ph(PH);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_ph(PH);
        scl = 1'b1;   wait_ph(PH);
        sda_m = 1'b1; wait_ph(PH);
    endtask

    task automatic bus_bit(input logic b);
        sda_m = b;  wait_ph(PH);
        scl = 1'b1; wait_ph(PH);
        scl = 1'b0; wait_ph(PH);
    endtask

    // Eight bits plus the ninth clock; returns whether it was acknowledged.
    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        sda_m = 1'b1; wait_ph(PH);
        scl = 1'b1;   wait_ph(PH);
        acked = ~sda_line;
        scl = 1'b0;   wait_ph(PH);
        check("R13 pull released after ninth fall", sda_pull, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 reset pull", sda_pull, 1'b0);
        check("R1 reset selected", selected, 1'b0);
        check("R5 reset prot_active", prot_active, 1'b0);
        check("R8 reset prot_perm", prot_perm, 1'b0);
    endtask

    task automatic t_array();
        logic a;
        bus_start(); send_byte({4'b1010, STRAP, 1'b1}, a);
        check("R3 array read ack", a, 1'b1);
        check("R3 selected", selected, 1'b1);
        check("R2 rd_wr read", rd_wr, 1'b1);
        bus_stop();
        check("R12 stop deselects", selected, 1'b0);
        bus_start(); send_byte({4'b1010, STRAP, 1'b0}, a);
        check("R3 array write ack", a, 1'b1);
        check("R2 rd_wr write", rd_wr, 1'b0);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start(); send_byte({4'b1010, 3'b100, 1'b1}, a);
        check("R4 ce mismatch nack", a, 1'b0);
        check("R4 not selected", selected, 1'b0);
        send_byte({4'b1010, STRAP, 1'b1}, a);
        check("R4 standby ignores bits", a, 1'b0);
        bus_stop();
        bus_start(); send_byte({4'b1011, STRAP, 1'b0}, a);
        check("R4 unknown type nack", a, 1'b0);
        bus_stop();
        send_byte({4'b1010, STRAP, 1'b1}, a);
        check("R1 no start no ack", a, 1'b0);
    endtask

    task automatic t_protect();
        logic a;
        a0_hv = 1'b0;
        bus_start(); send_byte({4'b0110, 3'b001, 1'b0}, a); bus_stop();
        check("R7 set without hv nack", a, 1'b0);
        check("R7 flag unchanged", prot_active, 1'b0);
        a0_hv = 1'b1;
        bus_start(); send_byte({4'b0110, 3'b001, 1'b0}, a); bus_stop();
        check("R5 set ack", a, 1'b1);
        check("R5 prot_active set", prot_active, 1'b1);
        bus_start(); send_byte({4'b0110, 3'b001, 1'b1}, a); bus_stop();
        check("R10 read set ack", a, 1'b1);
        check("R10 flag kept", prot_active, 1'b1);
        bus_start(); send_byte({4'b0110, 3'b011, 1'b0}, a); bus_stop();
        check("R6 clear ack", a, 1'b1);
        check("R6 prot_active cleared", prot_active, 1'b0);
        a0_hv = 1'b0;
    endtask

    task automatic t_power();
        logic a;
        pwr_good = 1'b0;
        bus_start(); send_byte({4'b1010, STRAP, 1'b1}, a);
        check("R11 unpowered nack", a, 1'b0);
        check("R11 unpowered not selected", selected, 1'b0);
        bus_stop();
        pwr_good = 1'b1;
    endtask

    task automatic t_abort();
        logic a;
        bus_start();
        for (int i = 0; i < 4; i++) bus_bit(1'b1);
        bus_stop();
        send_byte({4'b1010, STRAP, 1'b1}, a);
        check("R12 stop mid-byte aborts", a, 1'b0);
        bus_start();
        for (int i = 0; i < 4; i++) bus_bit(1'b0);
        sda_m = 1'b1; wait_ph(PH);
        scl = 1'b1;   wait_ph(PH);
        sda_m = 1'b0; wait_ph(PH);
        scl = 1'b0;   wait_ph(PH);
        send_byte({4'b1010, STRAP, 1'b1}, a);
        check("R12 repeated start restarts", a, 1'b1);
        bus_stop();
    endtask

    task automatic t_permanent();
        logic a;
        a0_hv = 1'b0;
        bus_start(); send_byte({4'b0110, STRAP, 1'b0}, a); bus_stop();
        check("R8 perm ack", a, 1'b1);
        check("R8 prot_perm set", prot_perm, 1'b1);
        check("R8 prot_active set", prot_active, 1'b1);
        a0_hv = 1'b1;
        bus_start(); send_byte({4'b0110, 3'b011, 1'b0}, a); bus_stop();
        check("R9 clear after perm nack", a, 1'b0);
        check("R9 prot_active kept", prot_active, 1'b1);
        bus_start(); send_byte({4'b0110, 3'b001, 1'b0}, a); bus_stop();
        check("R9 set after perm nack", a, 1'b0);
        bus_start(); send_byte({4'b0110, 3'b011, 1'b1}, a); bus_stop();
        check("R10 read after perm ack", a, 1'b1);
        check("R9 prot_perm kept", prot_perm, 1'b1);
        a0_hv = 1'b0;
    endtask

    initial begin
        wait_ph(5);
        rst_n = 1'b1;
        wait_ph(2);
        t_reset();
        t_array();
        t_mismatch();
        t_protect();
        t_power();
        t_abort();
        t_permanent();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule